// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the period of a fan tachometer signal on one of sixteen input lines. A control agent writes a trigger word with exactly one bit set to name the channel. The block then waits for a qualifying edge on that line. From that edge it counts ticks of a prescaled clock until the next qualifying edge. It then posts the count, with a done flag, in a single shared result word.

The channel's settings are found in two steps. Each channel carries a 3-bit code that names one of eight PWM sources. Each source carries a type code, and that type selects a group of settings. A group holds the edge mode, the prescaler division and a 16-bit measurement window. The tach lines are asynchronous, so each one passes through two synchronizing flops before edge detection. The finite-state machine has three states. `ST_IDLE` holds the posted result. `ST_ARM` waits for the first qualifying edge. `ST_MEAS` counts ticks until the closing edge. The transitions are:
- start: from any state to `ST_ARM`, on a valid trigger;
- abort: from any state to `ST_IDLE`, on any other trigger write;
- open: from `ST_ARM` to `ST_MEAS`, on a qualifying edge;
- close: from `ST_MEAS` to `ST_IDLE`, on a qualifying edge, posting the count;
- expire: from `ST_ARM` or `ST_MEAS` to `ST_IDLE`, when the window runs out, posting zero.

Top module: `fan_tach_meas`

## Requirements
- R1: After reset the result word is all zeros.
- R2: A trigger write of exactly one set bit naming an enabled channel starts a measurement. On the cycle after any trigger write, the done flag and the count read zero.
- R3: A trigger write of all zeros, with more than one bit set, or naming a disabled channel starts nothing. The done flag stays zero.
- R4: Edge mode 01 counts ticks between two consecutive rising edges, to within one tick.
- R5: Edge mode 00 counts ticks between two consecutive falling edges, to within one tick.
- R6: Edge mode 10 accepts both edges. The count therefore covers half a tach period.
- R7: One tick lasts 4 << (2*div) clock cycles, where div is the 2-bit division field of the selected type.
- R8: The done flag is bit 31 and the count is bits 19:0. Bits 30:20 are always zero.
- R9: The routing fields are as follows. Channel c's source code sits at bits 3c+2:3c of `chan_src_i`. Source s's type code sits at bits 2s+1:2s of `src_type_i`. A type code of NUM_TYPES or above selects type 0. Activity on other channels has no effect.
- R10: The window is `unit` ticks, counted from the trigger. If the measurement is still unfinished when the window ends, done is set with a count of 0. A unit of 0 ends the measurement at once.
- R11: Edge mode 11 is reserved. No edge qualifies, so the measurement ends through the window with a count of 0.
- R12: The count saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_i | input | 16 | Asynchronous tach lines |
| chan_en_i | input | 16 | Per-channel enable |
| trig_wr_i | input | 1 | Trigger write strobe |
| trig_val_i | input | 16 | Trigger word, one-hot channel select |
| chan_src_i | input | 48 | 3-bit PWM source code per channel |
| src_type_i | input | 16 | 2-bit type code per source |
| type_mode_i | input | 6 | 2-bit edge mode per type |
| type_div_i | input | 6 | 2-bit prescaler division per type |
| type_unit_i | input | 48 | 16-bit window length per type |
| result_o | output | 32 | Done flag in bit 31, count in bits 19:0 |

## Verification
The hardest situation to reach is saturation. The count must grow past its width before the closing edge arrives, and that edge must still come inside the window. The bench reaches it by building the block with a 10-bit count. It then runs a slow tach whose period is longer than the count can hold but shorter than the window. Wrong-channel routing is the next hardest case to expose. To expose it, every channel that is not selected toggles fast throughout, so a wrong selection produces a count of about one tick.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2
    } meas_state_t;

    localparam logic [1:0] EDGE_FALL = 2'b00;
    localparam logic [1:0] EDGE_RISE = 2'b01;
    localparam logic [1:0] EDGE_BOTH = 2'b10;
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
    parameter int N_CH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] tach_i,
    output logic [N_CH-1:0] rise_o,
    output logic [N_CH-1:0] fall_o
);
    for (genvar g = 0; g < N_CH; g++) begin : g_line
        logic meta_q, sync_q, last_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= tach_i[g];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign rise_o[g] = sync_q & ~last_q;
        assign fall_o[g] = ~sync_q & last_q;
    end
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int PW = 3 + 2 * ((1 << DIV_W) - 1);

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] last_val;

    assign last_val = (PW'(4) << {div_i, 1'b0}) - PW'(1);
    assign tick_o   = (cnt_q >= last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart_i)      cnt_q <= '0;
        else if (cnt_q >= last_val) cnt_q <= '0;
        else                     cnt_q <= cnt_q + PW'(1);
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/tach_cfg_select.sv
module tach_cfg_select #(
    parameter int N_CH      = 16,
    parameter int N_SRC     = 8,
    parameter int NUM_TYPES = 3,
    parameter int TYPE_W    = 2,
    parameter int DIV_W     = 2,
    parameter int UNIT_W    = 16,
    localparam int CH_W     = $clog2(N_CH),
    localparam int SRC_W    = $clog2(N_SRC)
) (
    input  logic [CH_W-1:0]             chan_i,
    input  logic [N_CH*SRC_W-1:0]       chan_src_i,
    input  logic [N_SRC*TYPE_W-1:0]     src_type_i,
    input  logic [NUM_TYPES*2-1:0]      type_mode_i,
    input  logic [NUM_TYPES*DIV_W-1:0]  type_div_i,
    input  logic [NUM_TYPES*UNIT_W-1:0] type_unit_i,
    output logic [1:0]                  mode_o,
    output logic [DIV_W-1:0]            div_o,
    output logic [UNIT_W-1:0]           unit_o
);
    logic [SRC_W-1:0]  src;
    logic [TYPE_W-1:0] typ;
    int unsigned       tsel;

    always_comb begin
        src    = chan_src_i[int'(chan_i)*SRC_W +: SRC_W];
        typ    = src_type_i[int'(src)*TYPE_W +: TYPE_W];
        tsel   = (int'(typ) < NUM_TYPES) ? int'(typ) : 0;
        mode_o = type_mode_i[tsel*2 +: 2];
        div_o  = type_div_i[tsel*DIV_W +: DIV_W];
        unit_o = type_unit_i[tsel*UNIT_W +: UNIT_W];
    end
endmodule

// File: rtl/fan_tach_meas.sv
module fan_tach_meas
    import fan_tach_pkg::*;
#(
    parameter int N_CH      = 16,
    parameter int N_SRC     = 8,
    parameter int NUM_TYPES = 3,
    parameter int TYPE_W    = 2,
    parameter int DIV_W     = 2,
    parameter int UNIT_W    = 16,
    parameter int CNT_W     = 20,
    localparam int CH_W     = $clog2(N_CH),
    localparam int SRC_W    = $clog2(N_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CH-1:0]             tach_i,
    input  logic [N_CH-1:0]             chan_en_i,
    input  logic                        trig_wr_i,
    input  logic [N_CH-1:0]             trig_val_i,
    input  logic [N_CH*SRC_W-1:0]       chan_src_i,
    input  logic [N_SRC*TYPE_W-1:0]     src_type_i,
    input  logic [NUM_TYPES*2-1:0]      type_mode_i,
    input  logic [NUM_TYPES*DIV_W-1:0]  type_div_i,
    input  logic [NUM_TYPES*UNIT_W-1:0] type_unit_i,
    output logic [31:0]                 result_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_state_t       state, nxt;
    logic [CH_W-1:0]   chan_q, chan_enc;
    logic [CNT_W-1:0]  cnt_q, res_q;
    logic [UNIT_W-1:0] win_q;
    logic              done_q;

    logic [N_CH-1:0]   rise, fall;
    logic [1:0]        mode;
    logic [DIV_W-1:0]  div;
    logic [UNIT_W-1:0] unit;
    logic              tick, qual, expired, start;

    tach_edge_sync #(.N_CH(N_CH)) i_sync (
        .clk(clk), .rst_n(rst_n), .tach_i(tach_i),
        .rise_o(rise), .fall_o(fall)
    );

    tach_cfg_select #(
        .N_CH(N_CH), .N_SRC(N_SRC), .NUM_TYPES(NUM_TYPES), .TYPE_W(TYPE_W),
        .DIV_W(DIV_W), .UNIT_W(UNIT_W)
    ) i_cfg (
        .chan_i(chan_q), .chan_src_i(chan_src_i), .src_type_i(src_type_i),
        .type_mode_i(type_mode_i), .type_div_i(type_div_i),
        .type_unit_i(type_unit_i),
        .mode_o(mode), .div_o(div), .unit_o(unit)
    );

    tach_prescaler #(.DIV_W(DIV_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .restart_i(trig_wr_i),
        .div_i(div), .tick_o(tick)
    );

    always_comb begin
        chan_enc = '0;
        for (int i = 0; i < N_CH; i++)
            if (trig_val_i[i]) chan_enc = CH_W'(i);
    end

    assign start   = trig_wr_i && $onehot(trig_val_i)
                     && |(trig_val_i & chan_en_i);
    assign expired = (win_q >= unit);

    always_comb begin
        unique case (mode)
            EDGE_FALL: qual = fall[chan_q];
            EDGE_RISE: qual = rise[chan_q];
            EDGE_BOTH: qual = rise[chan_q] | fall[chan_q];
            default:   qual = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        if (trig_wr_i) begin
            nxt = start ? ST_ARM : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ARM:  if (qual) nxt = ST_MEAS;
                         else if (expired) nxt = ST_IDLE;
                ST_MEAS: if (qual || expired) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            cnt_q  <= '0;
            res_q  <= '0;
            win_q  <= '0;
            done_q <= 1'b0;
        end else if (trig_wr_i) begin
            done_q <= 1'b0;
            res_q  <= '0;
            cnt_q  <= '0;
            win_q  <= '0;
            if (start) chan_q <= chan_enc;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ARM: begin
                    if (tick && !expired) win_q <= win_q + UNIT_W'(1);
                    if (!qual && expired) done_q <= 1'b1;
                end
                ST_MEAS: begin
                    if (tick && !expired) win_q <= win_q + UNIT_W'(1);
                    if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
                    if (qual) begin
                        done_q <= 1'b1;
                        res_q  <= cnt_q;
                    end else if (expired) begin
                        done_q <= 1'b1;
                        res_q  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign result_o = {done_q, 11'b0, 20'(res_q)};

    // R2
    trig_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr_i |=> !result_o[31]);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_o[31] |-> state == ST_IDLE);

    // R12
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEAS && $past(state) == ST_MEAS && !$past(trig_wr_i))
        |-> cnt_q >= $past(cnt_q));
endmodule

// File: tb/test_fan_tach_meas.sv
module test_fan_tach_meas;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tach;
    logic [15:0] chan_en;
    logic        trig_wr = 1'b0;
    logic [15:0] trig_val = '0;
    logic [47:0] chan_src = '0;
    logic [15:0] src_type = '0;
    logic [5:0]  type_mode = '0;
    logic [5:0]  type_div = '0;
    logic [47:0] type_unit = '0;
    logic [31:0] result;

    int errors = 0;
    int checks = 0;
    int hp = 0;
    int gen_ch = 0;
    logic main_lvl = 1'b0;
    logic noise_lvl = 1'b0;

    always #10 clk = ~clk;

    fan_tach_meas #(.CNT_W(10)) i_fan_tach_meas (
        .clk(clk), .rst_n(rst_n), .tach_i(tach), .chan_en_i(chan_en),
        .trig_wr_i(trig_wr), .trig_val_i(trig_val), .chan_src_i(chan_src),
        .src_type_i(src_type), .type_mode_i(type_mode), .type_div_i(type_div),
        .type_unit_i(type_unit), .result_o(result)
    );

    initial begin
        int pc = 0;
        int nc = 0;
        tach = '0;
        forever begin
            @(negedge clk);
            nc++;
            if (nc >= 3) begin nc = 0; noise_lvl = ~noise_lvl; end
            if (hp > 0) begin
                pc++;
                if (pc >= hp) begin pc = 0; main_lvl = ~main_lvl; end
            end
            for (int i = 0; i < 16; i++) tach[i] = (i == gen_ch) ? main_lvl : noise_lvl;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic trig(input logic [15:0] v);
        @(negedge clk);
        trig_wr = 1'b1; trig_val = v;
        @(negedge clk);
        trig_wr = 1'b0; trig_val = '0;
    endtask

    task automatic set_type(input int t, input logic [1:0] m, input logic [1:0] d,
                            input logic [15:0] u);
        type_mode[t*2 +: 2] = m;
        type_div[t*2 +: 2]  = d;
        type_unit[t*16 +: 16] = u;
    endtask

    task automatic set_map(input int ch, input int src, input logic [1:0] t);
        chan_src[ch*3 +: 3] = 3'(src);
        src_type[src*2 +: 2] = t;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (result[31]) break;
        end
    endtask

    task automatic measure(input int ch, input int half, input int exp,
                           input int tol, input string tag);
        int act;
        gen_ch = ch; hp = half;
        repeat (10) @(negedge clk);
        trig(16'h0000);
        trig(16'(1 << ch));
        wait_done(20000);
        act = int'(result[19:0]);
        chk(result[31] == 1'b1, {tag, " done"}, int'(result[31]), 1);
        chk(act >= exp - tol && act <= exp + tol, tag, act, exp);
        chk(result[30:20] == '0, "R8 reserved bits", int'(result[30:20]), 0);
    endtask

    task automatic t_reset;
        chk(result == 32'h0, "R1 reset result", int'(result), 0);
    endtask

    task automatic t_rise;
        set_map(3, 5, 2'd0);
        measure(3, 40, 20, 1, "R4 R9 rising count");
    endtask

    task automatic t_both;
        set_map(9, 2, 2'd1);
        measure(9, 80, 5, 1, "R6 R7 both-edge count");
    endtask

    task automatic t_fall;
        set_map(12, 7, 2'd2);
        measure(12, 40, 20, 1, "R5 falling count");
    endtask

    task automatic t_div2;
        set_type(1, 2'b01, 2'd2, 16'd1000);
        measure(9, 320, 10, 1, "R7 div2 count");
    endtask

    task automatic t_badtype;
        set_map(4, 6, 2'd3);
        measure(4, 40, 20, 1, "R9 type code 3 uses type 0");
    endtask

    task automatic t_timeout;
        set_type(2, 2'b00, 2'd0, 16'd50);
        measure(12, 0, 0, 0, "R10 no edge window expiry");
    endtask

    task automatic t_reserved;
        set_type(2, 2'b11, 2'd0, 16'd50);
        measure(12, 40, 0, 0, "R11 reserved mode");
    endtask

    task automatic t_unit0;
        set_type(2, 2'b00, 2'd0, 16'd0);
        gen_ch = 12; hp = 40;
        trig(16'(1 << 12));
        repeat (3) @(negedge clk);
        chk(result == 32'h8000_0000, "R10 unit zero ends at once", int'(result), 32'h8000_0000);
    endtask

    task automatic t_sat;
        set_type(0, 2'b01, 2'd0, 16'd3000);
        measure(3, 2200, 1023, 0, "R12 saturation");
    endtask

    task automatic t_clear;
        chk(result[31] == 1'b1, "R2 done before retrigger", int'(result[31]), 1);
        trig(16'(1 << 3));
        chk(result == 32'h0, "R2 trigger clears done", int'(result), 0);
    endtask

    task automatic t_abort;
        gen_ch = 3; hp = 2200;
        trig(16'(1 << 3));
        repeat (20) @(negedge clk);
        trig(16'h0000);
        repeat (9000) @(negedge clk);
        chk(result == 32'h0, "R3 zero write aborts", int'(result), 0);
    endtask

    task automatic t_multi;
        gen_ch = 3; hp = 40;
        trig(16'h0009);
        repeat (400) @(negedge clk);
        chk(result == 32'h0, "R3 non-one-hot ignored", int'(result), 0);
    endtask

    task automatic t_disabled;
        chan_en[3] = 1'b0;
        trig(16'(1 << 3));
        repeat (400) @(negedge clk);
        chk(result == 32'h0, "R3 disabled channel", int'(result), 0);
        chan_en[3] = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        chan_en = 16'hFFFF;
        set_type(0, 2'b01, 2'd0, 16'd1000);
        set_type(1, 2'b10, 2'd1, 16'd1000);
        set_type(2, 2'b00, 2'd0, 16'd200);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_rise();
        t_both();
        t_fall();
        t_div2();
        t_badtype();
        t_timeout();
        t_reserved();
        t_unit0();
        t_sat();
        t_clear();
        t_abort();
        t_multi();
        t_disabled();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule